// File: doc/BRIEF.md
# Operand Bypass Selector for a Five-Stage Pipeline

This block is the combinational bypass logic of an in-order five-stage integer pipeline. It sits beside the decode and execute stages and decides, for each of the two source operands, where the operand value should come from. It compares the source register numbers of the consumer instruction with the destination registers of the older instructions still in flight. Those older instructions are the one in execute-result position (stage 2), the one in memory-result position (stage 3) and, after a load stall, a delayed one (stage 4). When a newer result exists, the block selects it in place of the value read from the register file or held in the operand latch. When an instruction matches several producers, the youngest one wins.

There are two picking stages. The decode picker chooses between the register file, the execute result, the memory-stage result and a size-adjusted loaded value. The execute picker overrides the operand latches that feed the ALU, the address adder and the store-data path. Its sources are the execute result, the current load data and a delayed copy of the load data kept for the case where a load is written back during a stall. Jump, branch and trap instructions never take a bypassed value; their hazards are left to instruction scheduling. Stall generation is not part of this block.

Top module: `fwd_bypass_sel`

## Requirements
- R1: At decode, an eligible operand whose register equals the stage-2 producer destination selects the execute result (decode select code 1), even when stage 3 also matches.
- R2: At decode, an eligible operand that matches only the stage-3 producer selects the memory-stage result (code 2), or the size-adjusted load data (code 3) when the stage-3 instruction is a load. No match selects the register file (code 0).
- R3: Load data is adjusted by a size code and a sign flag. Size 0 keeps bits 7:0, size 1 keeps bits 15:0, and sizes 2 and 3 keep the whole word. With the sign flag at 1 the kept field is sign-extended; with it at 0 the field is zero-extended.
- R4: At execute, an eligible operand that matches the stage-2 producer selects the execute result (execute select code 1), ahead of any older match.
- R5: At execute, an operand that matches stage 3 but not stage 2 selects the load data adjusted with stage 3's size and sign (code 2) only when stage 3 is a load. A non-load stage-3 match leaves the latch value (code 0).
- R6: At execute, an operand that matches only a stage-4 load selects the delayed load data adjusted with stage 4's size and sign (code 3).
- R7: An ALU consumer in immediate form (imm flag 1) compares only its first operand; its second operand always keeps the register-file or latch value.
- R8: Load and store consumers compare their first (address) operand. Only a store compares its second (data) operand.
- R9: Consumer classes jump (7), branch (8), trap (9) and none (0), as well as a consumer whose valid flag is 0, never select a bypassed value at either stage.
- R10: Only a valid producer of class ALU (1), load (2), link (4) or special-to-register move (5) can match. Class store is 3 and register-to-special move is 6; these and any producer whose valid flag is 0 never match.
- R11: Register 0 never matches, whatever the producers' destinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_vld | input | 1 | Decode-stage instruction valid |
| id_cls | input | 4 | Decode-stage instruction class |
| id_imm | input | 1 | Decode-stage instruction is immediate form |
| id_src1 | input | RW | Decode first source register |
| id_src2 | input | RW | Decode second source register |
| rf_a | input | DW | Register-file value of first source |
| rf_b | input | DW | Register-file value of second source |
| ex_vld | input | 1 | Execute-stage instruction valid |
| ex_cls | input | 4 | Execute-stage instruction class |
| ex_imm | input | 1 | Execute-stage instruction is immediate form |
| ex_src1 | input | RW | Execute first source register |
| ex_src2 | input | RW | Execute second source register |
| lat_a | input | DW | First operand latch |
| lat_b | input | DW | Second operand latch |
| p2_vld | input | 1 | Stage-2 producer valid |
| p2_cls | input | 4 | Stage-2 producer class |
| p2_dst | input | RW | Stage-2 producer destination |
| p3_vld | input | 1 | Stage-3 producer valid |
| p3_cls | input | 4 | Stage-3 producer class |
| p3_dst | input | RW | Stage-3 producer destination |
| p3_lsz | input | 2 | Stage-3 load size code |
| p3_lsgn | input | 1 | Stage-3 load sign flag |
| p4_vld | input | 1 | Stage-4 producer valid |
| p4_cls | input | 4 | Stage-4 producer class |
| p4_dst | input | RW | Stage-4 producer destination |
| p4_lsz | input | 2 | Stage-4 load size code |
| p4_lsgn | input | 1 | Stage-4 load sign flag |
| exr_c | input | DW | Execute-stage result |
| memr_c1 | input | DW | Memory-stage copy of the result |
| lmdr_q | input | DW | Current load data register |
| lmdr_d1 | input | DW | Delayed copy of load data |
| id_a_sel | output | 2 | Decode first operand select |
| id_b_sel | output | 2 | Decode second operand select |
| id_a | output | DW | Decode first operand value |
| id_b | output | DW | Decode second operand value |
| ex_a_sel | output | 2 | Execute first operand select |
| ex_b_sel | output | 2 | Execute second operand select |
| ex_a | output | DW | Execute first operand value |
| ex_b | output | DW | Execute second operand value |

## Verification
The block holds no state, so a wrong compare or a wrong priority shows at the select and value ports in the same cycle as the input pattern that triggers it. A priority fault only appears when two or more producers name the same register. A size or sign fault in the load adjustment only appears when the loaded byte or halfword has its top bit set. For that reason the directed patterns pair overlapping destinations with loaded data whose upper bits are set, and a pseudo-random sweep over a small register range produces many multi-match cases.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [3:0] {
    CLS_NONE   = 4'd0,
    CLS_ALU    = 4'd1,
    CLS_LOAD   = 4'd2,
    CLS_STORE  = 4'd3,
    CLS_LINK   = 4'd4,
    CLS_S2I    = 4'd5,
    CLS_I2S    = 4'd6,
    CLS_JUMP   = 4'd7,
    CLS_BRANCH = 4'd8,
    CLS_TRAP   = 4'd9
  } op_cls_e;

  localparam logic [1:0] DSEL_RF   = 2'd0;
  localparam logic [1:0] DSEL_EXR  = 2'd1;
  localparam logic [1:0] DSEL_MEMR = 2'd2;
  localparam logic [1:0] DSEL_LD   = 2'd3;

  localparam logic [1:0] XSEL_LAT  = 2'd0;
  localparam logic [1:0] XSEL_EXR  = 2'd1;
  localparam logic [1:0] XSEL_LD   = 2'd2;
  localparam logic [1:0] XSEL_LD1  = 2'd3;

  // producer classes that write a destination register
  function automatic logic cls_writes(input logic [3:0] c);
    return (c == CLS_ALU) || (c == CLS_LOAD) || (c == CLS_LINK) || (c == CLS_S2I);
  endfunction

  // first operand eligible for bypass
  function automatic logic cls_fwd_first(input logic [3:0] c);
    return (c == CLS_ALU) || (c == CLS_LOAD) || (c == CLS_STORE) || (c == CLS_I2S);
  endfunction

  // second operand eligible for bypass
  function automatic logic cls_fwd_second(input logic [3:0] c, input logic imm);
    return ((c == CLS_ALU) && !imm) || (c == CLS_STORE);
  endfunction

  function automatic logic cls_is_load(input logic [3:0] c);
    return c == CLS_LOAD;
  endfunction

endpackage

// File: rtl/fwd_load_align.sv
module fwd_load_align #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] raw,
  input  logic [1:0]    sz,
  input  logic          sgn,
  output logic [DW-1:0] val
);
  localparam int BW = 8;
  localparam int HW = 16;

  function automatic logic [DW-1:0] widen(input logic [DW-1:0] r,
                                          input logic [1:0] s,
                                          input logic sg);
    logic [DW-1:0] o;
    case (s)
      2'd0:    o = {{(DW-BW){sg & r[BW-1]}}, r[BW-1:0]};
      2'd1:    o = {{(DW-HW){sg & r[HW-1]}}, r[HW-1:0]};
      default: o = r;
    endcase
    return o;
  endfunction

  assign val = widen(raw, sz, sgn);

  always_comb begin
    // R3
    if (sz == 2'd0 && !sgn)
      byte_zero_ext_chk: assert (val[DW-1:BW] == '0 && val[BW-1:0] == raw[BW-1:0])
        else $error("byte zero-extend mismatch");
  end
endmodule

// File: rtl/fwd_dec_pick.sv
module fwd_dec_pick
  import fwd_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          use_op,
  input  logic [RW-1:0] src,
  input  logic          p2_prod,
  input  logic [RW-1:0] p2_dst,
  input  logic          p3_prod,
  input  logic          p3_ld,
  input  logic [RW-1:0] p3_dst,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] c_val,
  input  logic [DW-1:0] c1_val,
  input  logic [DW-1:0] ld_val,
  output logic [1:0]    sel,
  output logic [DW-1:0] val
);
  logic src_live, hit2, hit3;

  assign src_live = use_op && (src != '0);
  assign hit2     = src_live && p2_prod && (src == p2_dst);
  assign hit3     = src_live && p3_prod && (src == p3_dst);

  always_comb begin
    sel = DSEL_RF;
    if (hit2)      sel = DSEL_EXR;
    else if (hit3) sel = p3_ld ? DSEL_LD : DSEL_MEMR;
  end

  always_comb begin
    case (sel)
      DSEL_EXR:  val = c_val;
      DSEL_MEMR: val = c1_val;
      DSEL_LD:   val = ld_val;
      default:   val = rf_val;
    endcase
  end

  always_comb begin
    // R2
    if (sel == DSEL_MEMR)
      dec_memr_older_chk: assert (!hit2 && val == c1_val)
        else $error("memory-stage pick with younger match");
  end
endmodule

// File: rtl/fwd_ex_pick.sv
module fwd_ex_pick
  import fwd_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          use_op,
  input  logic [RW-1:0] src,
  input  logic          p2_prod,
  input  logic [RW-1:0] p2_dst,
  input  logic          p3_prod,
  input  logic          p3_ld,
  input  logic [RW-1:0] p3_dst,
  input  logic          p4_prod,
  input  logic          p4_ld,
  input  logic [RW-1:0] p4_dst,
  input  logic [DW-1:0] lat_val,
  input  logic [DW-1:0] c_val,
  input  logic [DW-1:0] ld_val,
  input  logic [DW-1:0] ld1_val,
  output logic [1:0]    sel,
  output logic [DW-1:0] val
);
  logic src_live, hit2, hit3, hit4;

  assign src_live = use_op && (src != '0);
  assign hit2     = src_live && p2_prod && (src == p2_dst);
  assign hit3     = src_live && p3_prod && (src == p3_dst);
  assign hit4     = src_live && p4_prod && (src == p4_dst);

  always_comb begin
    sel = XSEL_LAT;
    if (hit2)               sel = XSEL_EXR;
    else if (hit3)          sel = p3_ld ? XSEL_LD : XSEL_LAT;
    else if (hit4 && p4_ld) sel = XSEL_LD1;
  end

  always_comb begin
    case (sel)
      XSEL_EXR: val = c_val;
      XSEL_LD:  val = ld_val;
      XSEL_LD1: val = ld1_val;
      default:  val = lat_val;
    endcase
  end

  always_comb begin
    // R5
    if (sel == XSEL_LD)
      ex_ld_src_chk: assert (p3_ld && val == ld_val)
        else $error("load-data pick without stage-3 load");
  end
endmodule

// File: rtl/fwd_bypass_sel.sv
module fwd_bypass_sel
  import fwd_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          id_vld,
  input  logic [3:0]    id_cls,
  input  logic          id_imm,
  input  logic [RW-1:0] id_src1,
  input  logic [RW-1:0] id_src2,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic          ex_vld,
  input  logic [3:0]    ex_cls,
  input  logic          ex_imm,
  input  logic [RW-1:0] ex_src1,
  input  logic [RW-1:0] ex_src2,
  input  logic [DW-1:0] lat_a,
  input  logic [DW-1:0] lat_b,
  input  logic          p2_vld,
  input  logic [3:0]    p2_cls,
  input  logic [RW-1:0] p2_dst,
  input  logic          p3_vld,
  input  logic [3:0]    p3_cls,
  input  logic [RW-1:0] p3_dst,
  input  logic [1:0]    p3_lsz,
  input  logic          p3_lsgn,
  input  logic          p4_vld,
  input  logic [3:0]    p4_cls,
  input  logic [RW-1:0] p4_dst,
  input  logic [1:0]    p4_lsz,
  input  logic          p4_lsgn,
  input  logic [DW-1:0] exr_c,
  input  logic [DW-1:0] memr_c1,
  input  logic [DW-1:0] lmdr_q,
  input  logic [DW-1:0] lmdr_d1,
  output logic [1:0]    id_a_sel,
  output logic [1:0]    id_b_sel,
  output logic [DW-1:0] id_a,
  output logic [DW-1:0] id_b,
  output logic [1:0]    ex_a_sel,
  output logic [1:0]    ex_b_sel,
  output logic [DW-1:0] ex_a,
  output logic [DW-1:0] ex_b
);
  localparam int NOPS = 2;

  // producer qualification, brought out for the assertions
  logic p2_prod, p3_prod, p4_prod, p3_ld, p4_ld;
  assign p2_prod = p2_vld && cls_writes(p2_cls);
  assign p3_prod = p3_vld && cls_writes(p3_cls);
  assign p4_prod = p4_vld && cls_writes(p4_cls);
  assign p3_ld   = cls_is_load(p3_cls);
  assign p4_ld   = cls_is_load(p4_cls);

  // adjusted load data for both load-data registers
  logic [DW-1:0] ld3_adj, ld4_adj;
  fwd_load_align #(.DW(DW)) u_al3 (.raw(lmdr_q),  .sz(p3_lsz), .sgn(p3_lsgn), .val(ld3_adj));
  fwd_load_align #(.DW(DW)) u_al4 (.raw(lmdr_d1), .sz(p4_lsz), .sgn(p4_lsgn), .val(ld4_adj));

  // per-operand eligibility
  logic [NOPS-1:0]         id_use, ex_use;
  logic [NOPS-1:0][RW-1:0] id_src, ex_src;
  logic [NOPS-1:0][DW-1:0] rf_v, lat_v;
  logic [NOPS-1:0][1:0]    dsel, xsel;
  logic [NOPS-1:0][DW-1:0] dval, xval;

  assign id_use = {id_vld && cls_fwd_second(id_cls, id_imm), id_vld && cls_fwd_first(id_cls)};
  assign ex_use = {ex_vld && cls_fwd_second(ex_cls, ex_imm), ex_vld && cls_fwd_first(ex_cls)};
  assign id_src = {id_src2, id_src1};
  assign ex_src = {ex_src2, ex_src1};
  assign rf_v   = {rf_b, rf_a};
  assign lat_v  = {lat_b, lat_a};

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    fwd_dec_pick #(.DW(DW), .RW(RW)) u_dec (
      .use_op (id_use[k]),
      .src    (id_src[k]),
      .p2_prod(p2_prod),
      .p2_dst (p2_dst),
      .p3_prod(p3_prod),
      .p3_ld  (p3_ld),
      .p3_dst (p3_dst),
      .rf_val (rf_v[k]),
      .c_val  (exr_c),
      .c1_val (memr_c1),
      .ld_val (ld3_adj),
      .sel    (dsel[k]),
      .val    (dval[k])
    );
    fwd_ex_pick #(.DW(DW), .RW(RW)) u_ex (
      .use_op (ex_use[k]),
      .src    (ex_src[k]),
      .p2_prod(p2_prod),
      .p2_dst (p2_dst),
      .p3_prod(p3_prod),
      .p3_ld  (p3_ld),
      .p3_dst (p3_dst),
      .p4_prod(p4_prod),
      .p4_ld  (p4_ld),
      .p4_dst (p4_dst),
      .lat_val(lat_v[k]),
      .c_val  (exr_c),
      .ld_val (ld3_adj),
      .ld1_val(ld4_adj),
      .sel    (xsel[k]),
      .val    (xval[k])
    );
  end

  assign id_a_sel = dsel[0];
  assign id_b_sel = dsel[1];
  assign id_a     = dval[0];
  assign id_b     = dval[1];
  assign ex_a_sel = xsel[0];
  assign ex_b_sel = xsel[1];
  assign ex_a     = xval[0];
  assign ex_b     = xval[1];

  always_comb begin
    // R1
    if (id_a_sel == DSEL_EXR)
      dec_young_pick_chk: assert (id_a == exr_c && p2_dst == id_src1 && p2_vld)
        else $error("decode execute-result pick inconsistent");
    // R9
    if (id_vld && (id_cls == CLS_JUMP || id_cls == CLS_BRANCH || id_cls == CLS_TRAP))
      dec_ctl_nofwd_chk: assert (id_a_sel == DSEL_RF && id_b_sel == DSEL_RF && id_a == rf_a)
        else $error("control-flow consumer took bypass");
    // R11
    if (id_src1 == '0 && ex_src1 == '0)
      zero_reg_chk: assert (id_a_sel == DSEL_RF && ex_a_sel == XSEL_LAT)
        else $error("register zero matched");
    // R6
    if (ex_a_sel == XSEL_LD1)
      ex_delayed_load_chk: assert (p4_vld && p4_cls == CLS_LOAD && p4_dst == ex_src1)
        else $error("delayed load pick without stage-4 load");
    // R10
    if (!p2_vld && !p3_vld && !p4_vld)
      no_producer_chk: assert (id_a_sel == DSEL_RF && id_b_sel == DSEL_RF &&
                               ex_a_sel == XSEL_LAT && ex_b_sel == XSEL_LAT)
        else $error("bypass with no valid producer");
  end
endmodule

// File: tb/sim_fwd_bypass_sel.sv
module sim_fwd_bypass_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic id_vld = 0, id_imm = 0, ex_vld = 0, ex_imm = 0;
  logic [3:0] id_cls = 0, ex_cls = 0, p2_cls = 0, p3_cls = 0, p4_cls = 0;
  logic [4:0] id_src1 = 0, id_src2 = 0, ex_src1 = 0, ex_src2 = 0;
  logic [4:0] p2_dst = 0, p3_dst = 0, p4_dst = 0;
  logic p2_vld = 0, p3_vld = 0, p4_vld = 0, p3_lsgn = 0, p4_lsgn = 0;
  logic [1:0] p3_lsz = 0, p4_lsz = 0;
  logic [31:0] rf_a = 0, rf_b = 0, lat_a = 0, lat_b = 0;
  logic [31:0] exr_c = 0, memr_c1 = 0, lmdr_q = 0, lmdr_d1 = 0;
  logic [1:0] id_a_sel, id_b_sel, ex_a_sel, ex_b_sel;
  logic [31:0] id_a, id_b, ex_a, ex_b;

  fwd_bypass_sel u0 (.*);

  typedef struct {
    string tag;
    logic [1:0] das, dbs, xas, xbs;
    logic [31:0] da, db, xa, xb;
  } exp_t;
  exp_t q[$];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  function automatic logic writer(logic v, logic [3:0] c);
    return v && (c == 4'd1 || c == 4'd2 || c == 4'd4 || c == 4'd5);
  endfunction
  function automatic logic [31:0] adj(logic [31:0] r, logic [1:0] s, logic g);
    if (s == 2'd0) return g ? 32'($signed(r[7:0])) : 32'(r[7:0]);
    if (s == 2'd1) return g ? 32'($signed(r[15:0])) : 32'(r[15:0]);
    return r;
  endfunction
  function automatic logic may1(logic v, logic [3:0] c);
    return v && (c == 4'd1 || c == 4'd2 || c == 4'd3 || c == 4'd6);
  endfunction
  function automatic logic may2(logic v, logic [3:0] c, logic im);
    return v && ((c == 4'd1 && !im) || c == 4'd3);
  endfunction

  // decode reference: scan producers youngest first
  task automatic ref_dec(input logic u, input logic [4:0] s, input logic [31:0] rf,
                         output logic [1:0] sel, output logic [31:0] v);
    sel = 0; v = rf;
    if (u && s != 0) begin
      if (writer(p2_vld, p2_cls) && p2_dst == s) begin sel = 1; v = exr_c; end
      else if (writer(p3_vld, p3_cls) && p3_dst == s) begin
        if (p3_cls == 4'd2) begin sel = 3; v = adj(lmdr_q, p3_lsz, p3_lsgn); end
        else begin sel = 2; v = memr_c1; end
      end
    end
  endtask

  task automatic ref_ex(input logic u, input logic [4:0] s, input logic [31:0] lt,
                        output logic [1:0] sel, output logic [31:0] v);
    sel = 0; v = lt;
    if (u && s != 0) begin
      if (writer(p2_vld, p2_cls) && p2_dst == s) begin sel = 1; v = exr_c; end
      else if (writer(p3_vld, p3_cls) && p3_dst == s) begin
        if (p3_cls == 4'd2) begin sel = 2; v = adj(lmdr_q, p3_lsz, p3_lsgn); end
      end
      else if (writer(p4_vld, p4_cls) && p4_dst == s && p4_cls == 4'd2) begin
        sel = 3; v = adj(lmdr_d1, p4_lsz, p4_lsgn);
      end
    end
  endtask

  // driver side: compute expectation from applied inputs and queue it
  task automatic push(input string tag);
    exp_t e;
    e.tag = tag;
    ref_dec(may1(id_vld, id_cls), id_src1, rf_a, e.das, e.da);
    ref_dec(may2(id_vld, id_cls, id_imm), id_src2, rf_b, e.dbs, e.db);
    ref_ex(may1(ex_vld, ex_cls), ex_src1, lat_a, e.xas, e.xa);
    ref_ex(may2(ex_vld, ex_cls, ex_imm), ex_src2, lat_b, e.xbs, e.xb);
    q.push_back(e);
  endtask

  task automatic clr();
    id_vld = 0; id_cls = 0; id_imm = 0; id_src1 = 0; id_src2 = 0;
    ex_vld = 0; ex_cls = 0; ex_imm = 0; ex_src1 = 0; ex_src2 = 0;
    p2_vld = 0; p2_cls = 0; p2_dst = 0;
    p3_vld = 0; p3_cls = 0; p3_dst = 0; p3_lsz = 2; p3_lsgn = 0;
    p4_vld = 0; p4_cls = 0; p4_dst = 0; p4_lsz = 2; p4_lsgn = 0;
    rf_a = 32'hA0A0_0001; rf_b = 32'hB0B0_0002;
    lat_a = 32'h1A1A_0003; lat_b = 32'h1B1B_0004;
    exr_c = 32'hCCCC_0005; memr_c1 = 32'hC1C1_0006;
    lmdr_q = 32'h1234_F680; lmdr_d1 = 32'h5678_8091;
  endtask

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] ex);
    n_chk++;
    if (act !== ex) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, ex);
    end
  endtask

  // monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "id_a_sel", 32'(id_a_sel), 32'(e.das));
      chk(e.tag, "id_b_sel", 32'(id_b_sel), 32'(e.dbs));
      chk(e.tag, "ex_a_sel", 32'(ex_a_sel), 32'(e.xas));
      chk(e.tag, "ex_b_sel", 32'(ex_b_sel), 32'(e.xbs));
      chk(e.tag, "id_a", id_a, e.da);
      chk(e.tag, "id_b", id_b, e.db);
      chk(e.tag, "ex_a", ex_a, e.xa);
      chk(e.tag, "ex_b", ex_b, e.xb);
    end
  end

  task automatic step(input string tag);
    push(tag);
    @(posedge clk);
  endtask

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    // reset/idle pattern: nothing valid
    clr(); step("R9");
    // R1: stage-2 and stage-3 both match first source; younger wins
    clr(); id_vld = 1; id_cls = 1; id_src1 = 3; id_src2 = 4;
    p2_vld = 1; p2_cls = 1; p2_dst = 3; p3_vld = 1; p3_cls = 1; p3_dst = 3; step("R1");
    // R2: only stage 3 matches second source, non-load
    clr(); id_vld = 1; id_cls = 1; id_src1 = 3; id_src2 = 4;
    p3_vld = 1; p3_cls = 4; p3_dst = 4; step("R2");
    // R2 and R3: stage-3 load, signed byte
    clr(); id_vld = 1; id_cls = 1; id_src1 = 3; p3_vld = 1; p3_cls = 2; p3_dst = 3;
    p3_lsz = 0; p3_lsgn = 1; step("R3");
    // R3: unsigned halfword, then signed halfword
    p3_lsz = 1; p3_lsgn = 0; step("R3");
    p3_lsgn = 1; step("R3");
    // R4: execute first source against stage 2 with older stage-3 load also matching
    clr(); ex_vld = 1; ex_cls = 1; ex_src1 = 7; ex_src2 = 9;
    p2_vld = 1; p2_cls = 5; p2_dst = 7; p3_vld = 1; p3_cls = 2; p3_dst = 7; step("R4");
    // R5: stage-3 load matches second source; then a non-load match
    clr(); ex_vld = 1; ex_cls = 1; ex_src2 = 8; p3_vld = 1; p3_cls = 2; p3_dst = 8; p3_lsz = 0; step("R5");
    p3_cls = 1; step("R5");
    // R6: only stage-4 load matches; then stage 3 load overrides
    clr(); ex_vld = 1; ex_cls = 2; ex_src1 = 9; p4_vld = 1; p4_cls = 2; p4_dst = 9;
    p4_lsz = 0; p4_lsgn = 1; step("R6");
    p3_vld = 1; p3_cls = 2; p3_dst = 9; step("R6");
    p3_cls = 1; step("R6");
    // R7: immediate form ignores second source match
    clr(); id_vld = 1; id_cls = 1; id_imm = 1; id_src1 = 5; id_src2 = 6;
    ex_vld = 1; ex_cls = 1; ex_imm = 1; ex_src1 = 5; ex_src2 = 6;
    p2_vld = 1; p2_cls = 1; p2_dst = 6; step("R7");
    p2_dst = 5; step("R7");
    // R8: load second source ignored, store second source forwarded
    clr(); id_vld = 1; id_cls = 2; id_src1 = 10; id_src2 = 11;
    ex_vld = 1; ex_cls = 2; ex_src1 = 10; ex_src2 = 11;
    p2_vld = 1; p2_cls = 1; p2_dst = 11; step("R8");
    id_cls = 3; ex_cls = 3; step("R8");
    p2_dst = 10; step("R8");
    // R9: control-flow consumers and invalid consumer
    clr(); id_vld = 1; id_cls = 7; id_src1 = 12; ex_vld = 1; ex_cls = 8; ex_src1 = 12;
    p2_vld = 1; p2_cls = 1; p2_dst = 12; step("R9");
    id_cls = 9; ex_cls = 7; step("R9");
    id_cls = 1; id_vld = 0; ex_cls = 1; ex_vld = 0; step("R9");
    // R10: non-writing or invalid producers
    clr(); id_vld = 1; id_cls = 1; id_src1 = 13; id_src2 = 13;
    ex_vld = 1; ex_cls = 1; ex_src1 = 13; ex_src2 = 13;
    p2_vld = 1; p2_cls = 3; p2_dst = 13; p3_vld = 1; p3_cls = 6; p3_dst = 13; step("R10");
    p2_cls = 1; p2_vld = 0; p3_cls = 7; step("R10");
    p4_vld = 1; p4_cls = 3; p4_dst = 13; step("R10");
    // R11: register zero
    clr(); id_vld = 1; id_cls = 1; ex_vld = 1; ex_cls = 1;
    p2_vld = 1; p2_cls = 1; p2_dst = 0; p3_vld = 1; p3_cls = 2; p3_dst = 0;
    p4_vld = 1; p4_cls = 2; p4_dst = 0; step("R11");
    // sweep over a small register range to force multi-match priority
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      id_vld = lf[0]; id_cls = 4'(lf[3:1] % 10); id_imm = lf[4];
      id_src1 = 5'(lf[6:5]); id_src2 = 5'(lf[8:7]);
      ex_vld = lf[9]; ex_cls = 4'((lf[12:10] + 3'd1) % 10); ex_imm = lf[13];
      ex_src1 = 5'(lf[15:14]); ex_src2 = 5'(lf[2:1]);
      p2_vld = lf[5]; p2_cls = 4'(lf[11:9] % 7); p2_dst = 5'(lf[4:3]);
      p3_vld = lf[7]; p3_cls = 4'(lf[14:12] % 7); p3_dst = 5'(lf[10:9]);
      p4_vld = lf[11]; p4_cls = lf[15] ? 4'd2 : 4'd1; p4_dst = 5'(lf[13:12]);
      p3_lsz = lf[1:0]; p3_lsgn = lf[2]; p4_lsz = lf[4:3]; p4_lsgn = lf[6];
      lmdr_q = {lf, ~lf}; lmdr_d1 = {~lf, lf};
      exr_c = {lf, lf}; memr_c1 = {lf[7:0], lf, lf[15:8]};
      step(i % 2 == 0 ? "R4" : "R1");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule